// File: doc/BRIEF.md
# MAC Control Frame Receive Filter

This block sits behind the receive parser of an Ethernet MAC. At the end of every received frame it looks at fields that have already been decoded: the destination address, the EtherType, the control opcode and a frame-good flag. The good flag covers both the CRC check and the length check. From these fields it makes two separate decisions. The first is whether the frame is handed on to the host DMA engine or dropped. The second is whether the frame is a pause request that the transmit flow-control logic has to act on.

The two decisions come from two separate paths. The pause path depends only on what the frame is, so a software setting that discards pause frames never keeps the flow-control logic from seeing them. MAC control frames that carry any other opcode reach the host only when a separate pass enable is set. Ordinary data frames and damaged frames are never treated as control frames. They are always marked for forwarding, and later stages deal with them.

The decision is valid for one cycle, one clock after the end-of-frame strobe. A build option removes the output register for a same-cycle result. A new frame may end on every cycle.

Top module: `mcf_rx_filter`

## Requirements
- R1: With the default registered output, dec_valid_o is high in exactly the cycle after a cycle where eof_i was high. pause_hit_o and dec_forward_o are low whenever dec_valid_o is low.
- R2: A frame that ends with frame_ok_i low gets dec_forward_o=1 and pause_hit_o=0, whatever its other fields are.
- R3: A good frame whose EtherType is not 16'h8808 gets dec_forward_o=1 and pause_hit_o=0.
- R4: A good frame with EtherType 16'h8808 is a qualifying control frame only when its destination equals 48'h0180C2000001 or equals station_addr_i. The first address byte on the wire is held in bits [47:40]. A control frame with any other destination gets dec_forward_o=0 and pause_hit_o=0.
- R5: A qualifying control frame with opcode 16'h0001 raises pause_hit_o for one cycle, whether discard_pause_i is 0 or 1.
- R6: A qualifying control frame with opcode 16'h0001 gets dec_forward_o equal to the inverse of discard_pause_i.
- R7: A qualifying control frame with any opcode other than 16'h0001 gets pause_hit_o=0 and dec_forward_o equal to pass_other_ctrl_i.
- R8: While rst_n is low, all three outputs are 0.
- R9: Frames may end on consecutive cycles. Each decision depends only on the field values present in the cycle of its own eof_i strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eof_i | input | 1 | End-of-frame strobe; the field inputs are valid in this cycle |
| frame_ok_i | input | 1 | Frame passed the CRC and length checks |
| dest_addr_i | input | 48 | Destination address; first byte on the wire in [47:40] |
| ether_type_i | input | 16 | EtherType / length field |
| opcode_i | input | 16 | MAC control opcode |
| station_addr_i | input | 48 | Station address of this port |
| discard_pause_i | input | 1 | Drop pause frames from the host path |
| pass_other_ctrl_i | input | 1 | Forward control frames with non-pause opcodes |
| dec_valid_o | output | 1 | Decision strobe |
| dec_forward_o | output | 1 | 1 = forward to host DMA, 0 = drop |
| pause_hit_o | output | 1 | Pause request detected, pulse to flow control |

## Verification
The bench goes after pause frames that are sent to the multicast address and to the station address, with discard set. A design that ties the pause pulse to the forward decision loses flow control in this case. It sends damaged frames that carry a valid pause opcode; a design that skips the good-frame check would pause on corrupted data. It uses destinations that differ from a matching address by a single bit, and opcodes close to 16'h0001 such as 16'h0101 and 16'h0000, which catch a partial address or opcode compare. Back-to-back end-of-frame strobes with changing controls catch a design that uses a setting from a neighbouring cycle.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

   typedef enum logic [2:0] {
      CLS_NONE,
      CLS_PASS_DATA,
      CLS_FOREIGN_CTRL,
      CLS_PAUSE,
      CLS_OTHER_CTRL
   } mcf_class_e;

   typedef struct packed {
      logic valid;
      logic forward;
      logic pause;
   } mcf_decision_t;

   localparam mcf_decision_t DEC_IDLE = '{valid: 1'b0, forward: 1'b0, pause: 1'b0};

endpackage

// File: rtl/mcf_addr_match.sv
module mcf_addr_match #(
   parameter int              ADDR_W     = 48,
   parameter logic [ADDR_W-1:0] GROUP_ADDR = 48'h0180C2000001
) (
   input  logic [ADDR_W-1:0] dest_i,
   input  logic [ADDR_W-1:0] station_i,
   output logic              hit_group_o,
   output logic              hit_station_o,
   output logic              hit_any_o
);
   localparam int NBYTES = ADDR_W / 8;

   logic [NBYTES-1:0] grp_eq;
   logic [NBYTES-1:0] sta_eq;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign grp_eq[b] = (dest_i[b*8 +: 8] == GROUP_ADDR[b*8 +: 8]);
      assign sta_eq[b] = (dest_i[b*8 +: 8] == station_i[b*8 +: 8]);
   end

   assign hit_group_o   = &grp_eq;
   assign hit_station_o = &sta_eq;
   assign hit_any_o     = hit_group_o | hit_station_o;

endmodule

// File: rtl/mcf_classify.sv
module mcf_classify
   import mcf_pkg::*;
#(
   parameter int                TYPE_W    = 16,
   parameter int                OP_W      = 16,
   parameter logic [TYPE_W-1:0] CTRL_TYPE = 16'h8808,
   parameter logic [OP_W-1:0]   PAUSE_OP  = 16'h0001
) (
   input  logic              frame_ok_i,
   input  logic [TYPE_W-1:0] ether_type_i,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic              addr_hit_i,
   output mcf_class_e        cls_o
);
   logic is_ctrl;
   logic is_pause_op;

   assign is_ctrl     = frame_ok_i && (ether_type_i == CTRL_TYPE);
   assign is_pause_op = (opcode_i == PAUSE_OP);

   always_comb begin
      if (!is_ctrl)          cls_o = CLS_PASS_DATA;
      else if (!addr_hit_i)  cls_o = CLS_FOREIGN_CTRL;
      else if (is_pause_op)  cls_o = CLS_PAUSE;
      else                   cls_o = CLS_OTHER_CTRL;
   end

endmodule

// File: rtl/mcf_policy.sv
module mcf_policy
   import mcf_pkg::*;
(
   input  logic          eof_i,
   input  mcf_class_e    cls_i,
   input  logic          discard_pause_i,
   input  logic          pass_other_ctrl_i,
   output mcf_decision_t dec_o
);
   logic fwd;

   always_comb begin
      unique case (cls_i)
         CLS_PASS_DATA:    fwd = 1'b1;
         CLS_FOREIGN_CTRL: fwd = 1'b0;
         CLS_PAUSE:        fwd = !discard_pause_i;
         CLS_OTHER_CTRL:   fwd = pass_other_ctrl_i;
         default:          fwd = 1'b0;
      endcase
   end

   always_comb begin
      dec_o         = DEC_IDLE;
      dec_o.valid   = eof_i;
      dec_o.forward = eof_i && fwd;
      dec_o.pause   = eof_i && (cls_i == CLS_PAUSE);
   end

endmodule

// File: rtl/mcf_rx_filter.sv
module mcf_rx_filter
   import mcf_pkg::*;
#(
   parameter int                ADDR_W     = 48,
   parameter int                TYPE_W     = 16,
   parameter int                OP_W       = 16,
   parameter logic [ADDR_W-1:0] GROUP_ADDR = 48'h0180C2000001,
   parameter logic [TYPE_W-1:0] CTRL_TYPE  = 16'h8808,
   parameter logic [OP_W-1:0]   PAUSE_OP   = 16'h0001,
   parameter bit                OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eof_i,
   input  logic              frame_ok_i,
   input  logic [ADDR_W-1:0] dest_addr_i,
   input  logic [TYPE_W-1:0] ether_type_i,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic [ADDR_W-1:0] station_addr_i,
   input  logic              discard_pause_i,
   input  logic              pass_other_ctrl_i,
   output logic              dec_valid_o,
   output logic              dec_forward_o,
   output logic              pause_hit_o
);

   if (ADDR_W % 8 != 0 || ADDR_W < 8) begin : g_bad_addr_w
      $error("mcf_rx_filter: ADDR_W must be a positive multiple of 8");
   end
   if (TYPE_W < 1 || OP_W < 1) begin : g_bad_field_w
      $error("mcf_rx_filter: TYPE_W and OP_W must be positive");
   end

   logic          hit_group;
   logic          hit_station;
   logic          hit_any;
   mcf_class_e    cls;
   mcf_decision_t dec_next;
   mcf_decision_t dec_q;

   mcf_addr_match #(
      .ADDR_W     (ADDR_W),
      .GROUP_ADDR (GROUP_ADDR)
   ) u_addr (
      .dest_i        (dest_addr_i),
      .station_i     (station_addr_i),
      .hit_group_o   (hit_group),
      .hit_station_o (hit_station),
      .hit_any_o     (hit_any)
   );

   mcf_classify #(
      .TYPE_W    (TYPE_W),
      .OP_W      (OP_W),
      .CTRL_TYPE (CTRL_TYPE),
      .PAUSE_OP  (PAUSE_OP)
   ) u_cls (
      .frame_ok_i   (frame_ok_i),
      .ether_type_i (ether_type_i),
      .opcode_i     (opcode_i),
      .addr_hit_i   (hit_any),
      .cls_o        (cls)
   );

   mcf_policy u_pol (
      .eof_i             (eof_i),
      .cls_i             (cls),
      .discard_pause_i   (discard_pause_i),
      .pass_other_ctrl_i (pass_other_ctrl_i),
      .dec_o             (dec_next)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dec_q <= DEC_IDLE;
         else        dec_q <= dec_next;
      end
   end else begin : g_out_comb
      always_comb dec_q = rst_n ? dec_next : DEC_IDLE;
   end

   assign dec_valid_o   = dec_q.valid;
   assign dec_forward_o = dec_q.forward;
   assign pause_hit_o   = dec_q.pause;

   logic unused_hits;
   assign unused_hits = hit_group ^ hit_station;

endmodule

// File: rtl/mcf_rx_filter_chk.sv
module mcf_rx_filter_chk #(
   parameter int                ADDR_W     = 48,
   parameter int                TYPE_W     = 16,
   parameter int                OP_W       = 16,
   parameter logic [ADDR_W-1:0] GROUP_ADDR = 48'h0180C2000001,
   parameter logic [TYPE_W-1:0] CTRL_TYPE  = 16'h8808,
   parameter logic [OP_W-1:0]   PAUSE_OP   = 16'h0001,
   parameter bit                OUT_REG    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eof_i,
   input logic              frame_ok_i,
   input logic [ADDR_W-1:0] dest_addr_i,
   input logic [TYPE_W-1:0] ether_type_i,
   input logic [OP_W-1:0]   opcode_i,
   input logic [ADDR_W-1:0] station_addr_i,
   input logic              discard_pause_i,
   input logic              pass_other_ctrl_i,
   input logic              dec_valid_o,
   input logic              dec_forward_o,
   input logic              pause_hit_o
);
   logic good_ctrl;
   logic addr_ok;
   assign good_ctrl = eof_i && frame_ok_i && (ether_type_i == CTRL_TYPE);
   assign addr_ok   = (dest_addr_i == GROUP_ADDR) || (dest_addr_i == station_addr_i);

   AST_OUTPUTS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_hit_o || dec_forward_o) |-> dec_valid_o); // R1

   if (OUT_REG) begin : g_seq
      AST_EOF_GIVES_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
         eof_i |=> dec_valid_o); // R1
      AST_IDLE_NO_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
         !eof_i |=> !dec_valid_o); // R1
      AST_BAD_FRAME_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
         (eof_i && !frame_ok_i) |=> (dec_forward_o && !pause_hit_o)); // R2
      AST_DATA_FRAME_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
         (eof_i && frame_ok_i && ether_type_i != CTRL_TYPE) |=> (dec_forward_o && !pause_hit_o)); // R3
      AST_FOREIGN_CTRL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
         (good_ctrl && !addr_ok) |=> (!dec_forward_o && !pause_hit_o)); // R4
      AST_PAUSE_IGNORES_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
         (good_ctrl && addr_ok && opcode_i == PAUSE_OP) |=> pause_hit_o); // R5
      AST_PAUSE_FORWARD_RULE: assert property (@(posedge clk) disable iff (!rst_n)
         (good_ctrl && addr_ok && opcode_i == PAUSE_OP) |=> (dec_forward_o == !$past(discard_pause_i))); // R6
      AST_OTHER_CTRL_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         (good_ctrl && addr_ok && opcode_i != PAUSE_OP) |=>
            (!pause_hit_o && dec_forward_o == $past(pass_other_ctrl_i))); // R7
   end

endmodule

bind mcf_rx_filter mcf_rx_filter_chk #(
   .ADDR_W     (ADDR_W),
   .TYPE_W     (TYPE_W),
   .OP_W       (OP_W),
   .GROUP_ADDR (GROUP_ADDR),
   .CTRL_TYPE  (CTRL_TYPE),
   .PAUSE_OP   (PAUSE_OP),
   .OUT_REG    (OUT_REG)
) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .eof_i             (eof_i),
   .frame_ok_i        (frame_ok_i),
   .dest_addr_i       (dest_addr_i),
   .ether_type_i      (ether_type_i),
   .opcode_i          (opcode_i),
   .station_addr_i    (station_addr_i),
   .discard_pause_i   (discard_pause_i),
   .pass_other_ctrl_i (pass_other_ctrl_i),
   .dec_valid_o       (dec_valid_o),
   .dec_forward_o     (dec_forward_o),
   .pause_hit_o       (pause_hit_o)
);

// File: tb/mcf_rx_filter_bench.sv
module mcf_rx_filter_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [47:0] GRP = 48'h0180C2000001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eof = 1'b0;
   logic        ok = 1'b0;
   logic [47:0] dst = '0;
   logic [15:0] typ = '0;
   logic [15:0] op = '0;
   logic [47:0] sta = '0;
   logic        dp = 1'b0;
   logic        po = 1'b0;
   logic        v_o, f_o, p_o;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   logic  exp_v = 1'b0, exp_f = 1'b0, exp_p = 1'b0;
   string exp_tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   mcf_rx_filter u_mcf_rx_filter (
      .clk (clk), .rst_n (rst_n), .eof_i (eof), .frame_ok_i (ok),
      .dest_addr_i (dst), .ether_type_i (typ), .opcode_i (op),
      .station_addr_i (sta), .discard_pause_i (dp), .pass_other_ctrl_i (po),
      .dec_valid_o (v_o), .dec_forward_o (f_o), .pause_hit_o (p_o)
   );

   function automatic void model(input logic e, input logic k, input logic [47:0] d,
                                 input logic [15:0] t, input logic [15:0] o,
                                 input logic [47:0] s, input logic dpi, input logic poi,
                                 output logic v, output logic f, output logic p,
                                 output string tag);
      v = e; f = 1'b0; p = 1'b0;
      if (!e)                 tag = "R1";
      else if (!k)          begin f = 1'b1; tag = "R2"; end
      else if (t != 16'h8808) begin f = 1'b1; tag = "R3"; end
      else if (d != GRP && d != s) tag = "R4";
      else if (o == 16'h0001) begin f = !dpi; p = 1'b1; tag = "R5/R6"; end
      else                  begin f = poi; tag = "R7"; end
   endfunction

   task automatic check_out(input string tag);
      n_vec++;
      if (v_o !== exp_v || f_o !== exp_f || p_o !== exp_p) begin
         n_bad++;
         $display("FAIL %s: got v=%b f=%b p=%b expected v=%b f=%b p=%b",
                  tag, v_o, f_o, p_o, exp_v, exp_f, exp_p);
      end
   endtask

   task automatic step(input logic e, input logic k, input logic [47:0] d,
                       input logic [15:0] t, input logic [15:0] o,
                       input logic [47:0] s, input logic dpi, input logic poi);
      @(negedge clk);
      check_out(exp_tag);
      eof = e; ok = k; dst = d; typ = t; op = o; sta = s; dp = dpi; po = poi;
      model(e, k, d, t, o, s, dpi, poi, exp_v, exp_f, exp_p, exp_tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [47:0] st;
      void'($urandom(32'h5EED_0749));
      st = 48'h02AB_CD12_3456;
      // R8: reset state
      repeat (3) begin
         @(negedge clk);
         exp_v = 0; exp_f = 0; exp_p = 0;
         check_out("R8");
      end
      eof = 1'b1; ok = 1'b1; typ = 16'h8808; op = 16'h0001; dst = GRP;
      @(negedge clk);
      check_out("R8");
      eof = 1'b0;
      rst_n = 1'b1;
      exp_v = 0; exp_f = 0; exp_p = 0; exp_tag = "R1";

      // R5/R6: pause to group and station, discard on and off
      step(1, 1, GRP, 16'h8808, 16'h0001, st, 1, 0);
      step(1, 1, st,  16'h8808, 16'h0001, st, 1, 1);
      step(1, 1, st,  16'h8808, 16'h0001, st, 0, 0);
      step(0, 1, st,  16'h8808, 16'h0001, st, 0, 0);   // R1 idle
      // R2: damaged pause frame
      step(1, 0, GRP, 16'h8808, 16'h0001, st, 0, 0);
      // R7: near-miss opcodes
      step(1, 1, GRP, 16'h8808, 16'h0101, st, 0, 1);
      step(1, 1, st,  16'h8808, 16'h0000, st, 1, 0);
      // R4: single-bit-off destinations
      step(1, 1, GRP ^ 48'h1, 16'h8808, 16'h0001, st, 0, 1);
      step(1, 1, st ^ 48'h8000_0000_0000, 16'h8808, 16'h0002, st, 0, 1);
      // R3: data frame, EtherType one bit off
      step(1, 1, GRP, 16'h8809, 16'h0001, st, 1, 0);
      // station equal to the group address
      step(1, 1, GRP, 16'h8808, 16'h0001, GRP, 1, 0);
      // R9: back-to-back strobes with controls toggling each cycle
      for (int i = 0; i < 8; i++)
         step(1, 1, (i % 2) ? st : GRP, 16'h8808, (i % 3 == 0) ? 16'h0001 : 16'h0005,
              st, i[0], i[1]);

      // randomized frames
      for (int i = 0; i < 3000; i++) begin
         logic [47:0] d;
         logic [15:0] t, o;
         int sel;
         if (i % 200 == 0) st = {$urandom(), $urandom()} & 48'hFEFF_FFFF_FFFF;
         sel = $urandom_range(0, 3);
         case (sel)
            0: d = GRP;
            1: d = st;
            2: d = {$urandom(), $urandom()};
            default: d = (($urandom_range(0, 1) != 0) ? GRP : st) ^ (48'h1 << $urandom_range(0, 47));
         endcase
         t = ($urandom_range(0, 9) < 7) ? 16'h8808 : (($urandom_range(0, 1) != 0) ? 16'h0800 : 16'($urandom()));
         sel = $urandom_range(0, 9);
         o = (sel < 5) ? 16'h0001 : (sel < 7) ? 16'h0000 : 16'($urandom());
         step($urandom_range(0, 9) < 6, $urandom_range(0, 9) < 8, d, t, o, st,
              1'($urandom()), 1'($urandom()));
      end
      step(0, 0, '0, '0, '0, st, 0, 0);
      @(negedge clk);
      check_out(exp_tag);
      finish_run();
   end
endmodule